// File: doc/BRIEF.md
# SerDes Lane Override Sequencer

This block runs the receive and transmit override procedure for one lane of a SerDes PHY after a link reset. Its only path to the PHY is a simple register access master: it issues one read or one write at a time and waits for an acknowledge. A trigger starts a command for the selected lane, with a receive DPLL mode and a transmit attenuation code.

For the override command, the block first polls the lane's receive status until the half-rate flag drops, with a bounded number of polls. It then reads the receive status and writes a chain of modified copies of that word to the receive override register. The chain pulses the override enable and the DPLL reset and inserts the mode. A settle interval follows. Unless the attenuation code requests a skip, the block then runs a shorter chain on the transmit override register. The disable command clears the receive override enable with a single read-modify-write. A one-cycle done pulse closes each command.

Top module: `lane_override_seq`

## Requirements
- R1: All accesses for lane L (0..3) fall in the window 0x2000 + L*0x100. Transmit status is at offset 1, receive status at offset 2, transmit override at offset 4 and receive override at offset 5. Reads go only to the status offsets and writes only to the override offsets.
- R2: While `m_req` is high and `m_ack` is low, `m_we`, `m_addr` and `m_wdata` hold their values. Each cycle with `m_req` and `m_ack` both high completes exactly one transfer, and the response data is taken from `m_rdata` in that cycle.
- R3: The override command reads the receive status repeatedly while bit 0 (half-rate) of the returned word is 1. It stops after a read that returns 0, or after POLL_MAX reads, and proceeds in either case.
- R4: After polling, the block reads the receive status once more into a working word S. It then writes to the receive override register, in this order: S with bit 14 cleared; that value with bit 14 set; that value with bits [10:8] replaced by the mode; that value with bit 11 set; and that value with bit 11 cleared.
- R5: After the last receive override write is acknowledged, `m_req` stays low for exactly SETTLE_CYCLES cycles before the next transfer, or before done if there is no transmit step.
- R6: When attenuation bit 3 is 0, the block reads the transmit status into T. It then writes to the transmit override register: T with bit 15 cleared; that value with bit 15 set; and that value ORed with attenuation bits [2:0] placed at bits [12:10].
- R7: When attenuation bit 3 is 1, no transmit status read and no transmit override write occur.
- R8: The disable command (`go_disable` = 1 at the trigger) performs one receive status read and one receive override write of that word with bit 14 cleared. It performs no polling, no settle interval and no other access.
- R9: `done` is high for exactly one cycle, one cycle after the final transfer or after the settle interval ends. `busy` is high from the cycle after an accepted trigger through the done cycle, and low after it.
- R10: A trigger while `busy` is high is ignored. The running command's sequence and lane are unchanged, and no extra transfer follows.
- R11: After reset, `busy`, `done` and `m_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a command when idle |
| go_disable | input | 1 | With `go`: 1 selects the disable command, 0 selects the override |
| lane_sel | input | 2 | Lane index |
| dpll_mode | input | 3 | Receive DPLL mode written into bits [10:8] |
| tx_atten | input | 4 | Transmit attenuation; bit 3 skips the transmit step |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| m_req | output | 1 | Register access request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | 16 | Register address |
| m_wdata | output | 16 | Write data |
| m_ack | input | 1 | Access completes in this cycle |
| m_rdata | input | 16 | Read data, valid with `m_ack` |

## Verification
The checker assumes the access master raises `m_ack` only while `m_req` is high, and only for single cycles. It also assumes `go` is never raised during reset. The bench's slave model follows these rules. It counts latency cycles only while a request is pending, and it drops the acknowledge in the cycle after raising it. The bench drives triggers only at falling edges, for one cycle, and uses both zero-wait and multi-wait acknowledge latencies.

// File: rtl/lane_override_seq.sv
module lane_override_seq #(
  parameter int SETTLE_CYCLES = 3000000,
  parameter int POLL_MAX      = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        go_disable,
  input  logic [1:0]  lane_sel,
  input  logic [2:0]  dpll_mode,
  input  logic [3:0]  tx_atten,
  output logic        busy,
  output logic        done,
  output logic        m_req,
  output logic        m_we,
  output logic [15:0] m_addr,
  output logic [15:0] m_wdata,
  input  logic        m_ack,
  input  logic [15:0] m_rdata
);

  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [CW-1:0] SET_LAST  = CW'(SETTLE_CYCLES - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_RXRD, S_RXW, S_SETTLE,
    S_TXRD, S_TXW, S_DISRD, S_DISW, S_DONE
  } state_t;

  state_t        state;
  logic [1:0]    lane_q;
  logic [2:0]    mode_q;
  logic [3:0]    att_q;
  logic [15:0]   word;
  logic [2:0]    step;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic [2:0]    reg_off;
  logic          xfer;

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);
  assign m_req = (state == S_POLL) || (state == S_RXRD) || (state == S_RXW) ||
                 (state == S_TXRD) || (state == S_TXW) ||
                 (state == S_DISRD) || (state == S_DISW);
  assign m_we  = (state == S_RXW) || (state == S_TXW) || (state == S_DISW);
  assign xfer  = m_req && m_ack;
  assign m_addr = {6'b001000, lane_q, 5'b00000, reg_off};

  always_comb begin
    case (state)
      S_TXRD:          reg_off = 3'd1;
      S_TXW:           reg_off = 3'd4;
      S_RXW, S_DISW:   reg_off = 3'd5;
      default:         reg_off = 3'd2;
    endcase
  end

  always_comb begin
    m_wdata = word;
    case (state)
      S_RXW: begin
        case (step)
          3'd0:    m_wdata = word & ~16'h4000;
          3'd1:    m_wdata = word | 16'h4000;
          3'd2:    m_wdata = (word & ~16'h0700) | {5'b0, mode_q, 8'b0};
          3'd3:    m_wdata = word | 16'h0800;
          default: m_wdata = word & ~16'h0800;
        endcase
      end
      S_TXW: begin
        case (step)
          3'd0:    m_wdata = word & ~16'h8000;
          3'd1:    m_wdata = word | 16'h8000;
          default: m_wdata = word | {3'b0, att_q[2:0], 10'b0};
        endcase
      end
      S_DISW:  m_wdata = word & ~16'h4000;
      default: m_wdata = word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      lane_q <= '0;
      mode_q <= '0;
      att_q  <= '0;
      word   <= '0;
      step   <= '0;
      cnt    <= '0;
      pcnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          lane_q <= lane_sel;
          mode_q <= dpll_mode;
          att_q  <= tx_atten;
          pcnt   <= '0;
          step   <= '0;
          state  <= go_disable ? S_DISRD : S_POLL;
        end
        S_POLL: if (xfer) begin
          if (!m_rdata[0] || pcnt == POLL_LAST) state <= S_RXRD;
          else pcnt <= pcnt + 1'b1;
        end
        S_RXRD: if (xfer) begin
          word  <= m_rdata;
          step  <= '0;
          state <= S_RXW;
        end
        S_RXW: if (xfer) begin
          word <= m_wdata;
          if (step == 3'd4) begin
            cnt   <= '0;
            state <= S_SETTLE;
          end else step <= step + 1'b1;
        end
        S_SETTLE: begin
          if (cnt == SET_LAST) state <= att_q[3] ? S_DONE : S_TXRD;
          else cnt <= cnt + 1'b1;
        end
        S_TXRD: if (xfer) begin
          word  <= m_rdata;
          step  <= '0;
          state <= S_TXW;
        end
        S_TXW: if (xfer) begin
          word <= m_wdata;
          if (step == 3'd2) state <= S_DONE;
          else step <= step + 1'b1;
        end
        S_DISRD: if (xfer) begin
          word  <= m_rdata;
          state <= S_DISW;
        end
        S_DISW: if (xfer) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lane_override_seq_chk.sv
module lane_override_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic        busy,
  input logic        done,
  input logic        m_req,
  input logic        m_we,
  input logic [15:0] m_addr,
  input logic [15:0] m_wdata,
  input logic        m_ack
);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata));

  // R1
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> m_addr[15:10] == 6'b001000 && m_addr[7:3] == 5'd0 &&
              (m_addr[2:0] == 3'd1 || m_addr[2:0] == 3'd2 ||
               m_addr[2:0] == 3'd4 || m_addr[2:0] == 3'd5));

  // R1
  write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> (m_we == m_addr[2]));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_req && !done);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && !busy |=> busy);

endmodule

bind lane_override_seq lane_override_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack)
);

// File: tb/sim_lane_override_seq.sv
`timescale 1ns/1ps
module sim_lane_override_seq;
  localparam int PM = 8;
  localparam int SC = 12;

  logic clk = 0, rst_n = 0;
  logic go = 0, go_disable = 0;
  logic [1:0] lane_sel = 0;
  logic [2:0] dpll_mode = 0;
  logic [3:0] tx_atten = 0;
  logic busy, done, m_req, m_we, m_ack;
  logic [15:0] m_addr, m_wdata, m_rdata;

  always #2.5 clk = ~clk;

  lane_override_seq #(.SETTLE_CYCLES(SC), .POLL_MAX(PM)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .go_disable(go_disable),
    .lane_sel(lane_sel), .dpll_mode(dpll_mode), .tx_atten(tx_atten),
    .busy(busy), .done(done), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
  );

  int checks = 0, fails = 0;
  int lat = 0, lat_cnt = 0, half_left = 0;
  int log_n = 0, gap = 0, done_cnt = 0;
  logic        log_we [64];
  logic [15:0] log_ad [64];
  logic [15:0] log_dt [64];
  int exp_n = 0;
  logic        exp_we [64];
  logic [15:0] exp_ad [64];
  logic [15:0] exp_dt [64];

  function automatic logic [15:0] rx_val(int l);
    return 16'(16'h4B3A + l * 16'h1110);
  endfunction
  function automatic logic [15:0] tx_val(int l);
    return 16'(16'h9C26 + l * 16'h0404);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack <= 0; m_rdata <= 0; lat_cnt = 0;
    end else begin
      if (m_req && m_ack && log_n < 64) begin
        log_we[log_n] = m_we; log_ad[log_n] = m_addr;
        log_dt[log_n] = m_we ? m_wdata : m_rdata;
        log_n++;
      end
      if (busy && !m_req && !done) gap++;
      if (done) done_cnt++;
      if (m_req && !m_ack) begin
        if (lat_cnt >= lat) begin
          lat_cnt = 0;
          m_ack <= 1;
          if (m_addr[7:0] == 8'h02) begin
            m_rdata <= rx_val(int'(m_addr[9:8])) | {15'b0, half_left > 0};
            if (half_left > 0) half_left--;
          end else if (m_addr[7:0] == 8'h01) m_rdata <= tx_val(int'(m_addr[9:8]));
          else m_rdata <= 16'hDEAD;
        end else lat_cnt++;
      end else m_ack <= 0;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic we, logic [15:0] ad, logic [15:0] dt);
    exp_we[exp_n] = we; exp_ad[exp_n] = ad; exp_dt[exp_n] = dt; exp_n++;
  endtask

  task automatic build_ovr(int lane, int mode, int att, int half);
    logic [15:0] base, w;
    int p, rem;
    exp_n = 0;
    base = 16'(16'h2000 + lane * 256);
    p = (half + 1 < PM) ? half + 1 : PM;
    for (int i = 0; i < p; i++) push(0, base + 2, rx_val(lane) | {15'b0, i < half});
    rem = half - ((half < p) ? half : p);
    w = rx_val(lane) | {15'b0, rem > 0};
    push(0, base + 2, w);
    w = w & ~16'h4000; push(1, base + 5, w);
    w = w | 16'h4000;  push(1, base + 5, w);
    w = (w & ~16'h0700) | 16'(mode << 8); push(1, base + 5, w);
    w = w | 16'h0800;  push(1, base + 5, w);
    w = w & ~16'h0800; push(1, base + 5, w);
    if (!att[3]) begin
      w = tx_val(lane); push(0, base + 1, w);
      w = w & ~16'h8000; push(1, base + 4, w);
      w = w | 16'h8000;  push(1, base + 4, w);
      w = w | 16'((att & 7) << 10); push(1, base + 4, w);
    end
  endtask

  task automatic check_seq(string req, string what);
    int bad = -1;
    if (log_n != exp_n) begin
      check(0, req, {what, " transfer count"}, log_n, exp_n);
      return;
    end
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && (log_we[i] != exp_we[i] || log_ad[i] != exp_ad[i] || log_dt[i] != exp_dt[i]))
        bad = i;
    if (bad < 0) check(1, req, what, 0, 0);
    else check(0, req, {what, " entry addr/data"},
               {log_ad[bad], log_dt[bad]}, {exp_ad[bad], exp_dt[bad]});
  endtask

  task automatic launch(bit dis, int lane, int mode, int att, int half);
    @(negedge clk);
    log_n = 0; gap = 0; done_cnt = 0; half_left = half;
    go_disable = dis; lane_sel = 2'(lane); dpll_mode = 3'(mode); tx_atten = 4'(att);
    go = 1;
    @(negedge clk);
    go = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(!busy && !done && !m_req, "R11", "reset outputs quiet", {busy, done, m_req}, 0);
  endtask

  task automatic t_override(int lane, int mode, int att, int half, int l, string tag);
    lat = l;
    build_ovr(lane, mode, att, half);
    launch(0, lane, mode, att, half);
    wait_done();
    check_seq("R1 R3 R4 R6", tag);
    check(gap == SC, "R5", {tag, " settle gap"}, gap, SC);
    check(done_cnt == 1 && !busy, "R9", {tag, " done pulse"}, done_cnt, 1);
  endtask

  task automatic t_skip();
    lat = 1;
    build_ovr(1, 3, 4'b1010, 0);
    launch(0, 1, 3, 4'b1010, 0);
    wait_done();
    check_seq("R7", "attenuation bit3 skips transmit step");
    check(gap == SC, "R5", "settle gap before done", gap, SC);
  endtask

  task automatic t_poll_cap();
    lat = 0;
    build_ovr(2, 5, 3, 20);
    launch(0, 2, 5, 3, 20);
    wait_done();
    check_seq("R3", "poll gives up after POLL_MAX reads");
  endtask

  task automatic t_disable();
    lat = 2;
    exp_n = 0;
    push(0, 16'h2202, rx_val(2));
    push(1, 16'h2205, rx_val(2) & ~16'h4000);
    launch(1, 2, 7, 0, 0);
    wait_done();
    check_seq("R8", "disable read-modify-write");
    check(gap == 0, "R8", "disable has no settle", gap, 0);
    check(done_cnt == 1, "R9", "disable done pulse", done_cnt, 1);
  endtask

  task automatic t_ignore();
    int n0;
    lat = 0;
    build_ovr(0, 3, 4'b1000, 0);
    launch(0, 0, 3, 4'b1000, 0);
    repeat (3) @(negedge clk);
    go_disable = 1; lane_sel = 2'd3; go = 1;
    @(negedge clk);
    go = 0;
    wait_done();
    check_seq("R10", "trigger while busy ignored");
    n0 = log_n;
    repeat (10) @(negedge clk);
    check(log_n == n0 && !busy, "R10", "no extra transfer after done", log_n, n0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_override(0, 3, 5, 0, 0, "lane0 override");
    t_override(3, 6, 2, 3, 2, "lane3 override with half-rate polls");
    t_skip();
    t_poll_cap();
    t_disable();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule